// File: doc/BRIEF.md
# I2C Slave Receiver with Overrun Lockout

This block is the receive half of a byte-oriented I2C slave. It watches SCL and SDA using the system clock. After a START it shifts in a 7-bit address and the R/W bit, and compares the address with a programmable own address. If the address matches and the request is a write, it acknowledges the address. It then shifts in data bytes MSB first and acknowledges each byte it accepts. Each accepted byte is placed in a holding register, where it stays until software reads it. A ready flag and an optional interrupt tell software that a byte is waiting.

Software reads the byte and pulses a read strobe, which clears the ready flag. If a second byte finishes while the previous one is still unread, the block raises a sticky overrun flag, discards the new byte and does not acknowledge it. While the overrun flag is set, every later data byte is refused and discarded. This lasts until software clears the flag. A STOP or a repeated START always returns the block to address matching.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, rx_ready_o, overrun_o, amatch_o, xfer_mode_o, irq_o and sda_pull_o are all 0.
- R2: After a START, a received address byte whose upper 7 bits equal own_addr_i and whose bit 0 (R/W) is 0 is acknowledged. The acknowledge is SDA held low during the ninth SCL high phase. The same byte sets amatch_o to 1 and xfer_mode_o to 0.
- R3: If the address does not match, the block does not acknowledge it and leaves amatch_o unchanged. It also ignores all bus traffic, storing no data, until the next START.
- R4: A data byte received after an acknowledged write address is shifted in MSB first and appears on rx_data_o. If rx_ready_o and overrun_o were both 0, the byte sets rx_ready_o and is acknowledged.
- R5: A one-cycle pulse on buf_rd_i clears rx_ready_o.
- R6: If a data byte completes while rx_ready_o is 1, overrun_o is set to 1. That byte is not acknowledged, and rx_data_o keeps the earlier byte.
- R7: While overrun_o is 1, every data byte is refused and discarded, even after rx_ready_o has been cleared. Bytes are accepted again once ovr_clr_i has cleared overrun_o.
- R8: irq_o equals (amatch_o AND amatch_ie_i) OR (rx_ready_o AND rx_ie_i).
- R9: After a STOP, bytes clocked without a new START are ignored. A repeated START in the middle of a byte restarts address reception.
- R10: A matching address with R/W = 1 sets amatch_o and sets xfer_mode_o to 1, but is not acknowledged.
- R11: sda_pull_o goes high only while SCL is low. It returns low within 4 clock cycles after the falling edge of the ninth SCL pulse.
- R12: While enable_i is 0, the block never pulls SDA low and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Block enable |
| own_addr_i | input | 7 | Own slave address |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire |
| buf_rd_i | input | 1 | Read strobe for the receive buffer |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| amatch_clr_i | input | 1 | Clears the address-match flag |
| amatch_ie_i | input | 1 | Address-match interrupt enable |
| rx_ie_i | input | 1 | Receive-ready interrupt enable |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| rx_data_o | output | 8 | Last accepted data byte |
| rx_ready_o | output | 1 | Unread byte present |
| overrun_o | output | 1 | Sticky overrun flag |
| amatch_o | output | 1 | Address-match flag |
| xfer_mode_o | output | 1 | R/W bit of the last matched address |
| irq_o | output | 1 | Interrupt request |

## Verification
SCL and SDA go through a two-stage synchronizer and an edge register. Because of this, a flag or an SDA pull responds 3 to 4 system clocks after the bus edge that causes it. The bench holds every quarter of an SCL bit for 10 clocks. It reads the acknowledge in the middle of the ninth high phase and checks that SDA is released one quarter after the ninth falling edge. It checks flags and the buffer only after a STOP has settled, so no check samples within the synchronizer delay. Inputs are driven, and outputs sampled, 1 ns after a rising clock edge.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_SETUP,
    ST_ACK_HOLD,
    ST_DATA,
    ST_IGNORE
  } rx_state_t;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  logic [LINES-1:0] prev_q;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;  // idle bus is high
      else         chain_q <= {chain_q[STAGES-2:0], d_i[l]};
    end
    assign q_o[l] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= q_o;
  end

  assign rise_o = q_o & ~prev_q;
  assign fall_o = ~q_o & prev_q;
endmodule

// File: rtl/i2c_rx_shreg.sv
module i2c_rx_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic         done_o,
  output logic [W-1:0] byte_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  assign done_o = shift_i && (cnt_q == LAST);
  assign byte_o = {sh_q[W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= byte_o;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  assert_cnt_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/i2c_rx_flags.sv
module i2c_rx_flags #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         store_i,
  input  logic         ovr_set_i,
  input  logic         am_set_i,
  input  logic         mode_i,
  input  logic [W-1:0] byte_i,
  input  logic         rd_i,
  input  logic         ovr_clr_i,
  input  logic         am_clr_i,
  input  logic         am_ie_i,
  input  logic         rx_ie_i,
  output logic [W-1:0] data_o,
  output logic         rdy_o,
  output logic         ovr_o,
  output logic         am_o,
  output logic         mode_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      rdy_o  <= 1'b0;
      ovr_o  <= 1'b0;
      am_o   <= 1'b0;
      mode_o <= 1'b0;
    end else begin
      if (store_i) data_o <= byte_i;
      if (store_i)   rdy_o <= 1'b1;
      else if (rd_i) rdy_o <= 1'b0;
      if (ovr_set_i)      ovr_o <= 1'b1;
      else if (ovr_clr_i) ovr_o <= 1'b0;
      if (am_set_i)      am_o <= 1'b1;
      else if (am_clr_i) am_o <= 1'b0;
      if (am_set_i) mode_o <= mode_i;
    end
  end

  assign irq_o = (am_o & am_ie_i) | (rdy_o & rx_ie_i);

  assert_ovr_needs_unread_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(rdy_o));
  assert_ovr_holds_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> $stable(data_o));
  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !store_i) |=> !rdy_o);
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              buf_rd_i,
  input  logic              ovr_clr_i,
  input  logic              amatch_clr_i,
  input  logic              amatch_ie_i,
  input  logic              rx_ie_i,
  output logic              sda_pull_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ready_o,
  output logic              overrun_o,
  output logic              amatch_o,
  output logic              xfer_mode_o,
  output logic              irq_o
);
  localparam int SH_W = ADDR_W + 1;  // address byte and data byte share the shifter
  localparam int L_SCL = 0;
  localparam int L_SDA = 1;

  logic [1:0] line_q, line_rise, line_fall;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_rx_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i, .rst_ni,
    .d_i    ({sda_i, scl_i}),
    .q_o    (line_q),
    .rise_o (line_rise),
    .fall_o (line_fall)
  );

  assign scl_s     = line_q[L_SCL];
  assign sda_s     = line_q[L_SDA];
  assign scl_rise  = line_rise[L_SCL];
  assign scl_fall  = line_fall[L_SCL];
  assign start_det = line_fall[L_SDA] & scl_s;
  assign stop_det  = line_rise[L_SDA] & scl_s;

  rx_state_t st_q;
  logic ack_q;
  logic shift, done;
  logic [SH_W-1:0] rx_byte;

  assign shift = enable_i && scl_rise && (st_q == ST_ADDR || st_q == ST_DATA);

  i2c_rx_shreg #(.W(SH_W)) u_shreg (
    .clk_i, .rst_ni,
    .clr_i   (start_det | stop_det | ~enable_i),
    .shift_i (shift),
    .bit_i   (sda_s),
    .done_o  (done),
    .byte_o  (rx_byte)
  );

  logic addr_hit, data_done, store, ovr_set;
  assign addr_hit  = done && (st_q == ST_ADDR) && (rx_byte[SH_W-1:1] == own_addr_i);
  assign data_done = done && (st_q == ST_DATA);
  assign store     = data_done && !rx_ready_o && !overrun_o;
  assign ovr_set   = data_done && rx_ready_o;

  i2c_rx_flags #(.W(DATA_W)) u_flags (
    .clk_i, .rst_ni,
    .store_i   (store),
    .ovr_set_i (ovr_set),
    .am_set_i  (addr_hit),
    .mode_i    (rx_byte[0]),
    .byte_i    (rx_byte[DATA_W-1:0]),
    .rd_i      (buf_rd_i),
    .ovr_clr_i (ovr_clr_i),
    .am_clr_i  (amatch_clr_i),
    .am_ie_i   (amatch_ie_i),
    .rx_ie_i   (rx_ie_i),
    .data_o    (rx_data_o),
    .rdy_o     (rx_ready_o),
    .ovr_o     (overrun_o),
    .am_o      (amatch_o),
    .mode_o    (xfer_mode_o),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ack_q      <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (!enable_i) begin
      st_q       <= ST_IDLE;
      sda_pull_o <= 1'b0;
    end else if (start_det) begin
      st_q       <= ST_ADDR;
      sda_pull_o <= 1'b0;
    end else if (stop_det) begin
      st_q       <= ST_IDLE;
      sda_pull_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: if (done) begin
          if (addr_hit && !rx_byte[0]) begin
            ack_q <= 1'b1;
            st_q  <= ST_ACK_SETUP;
          end else begin
            st_q  <= ST_IGNORE;
          end
        end
        ST_DATA: if (done) begin
          ack_q <= store;
          st_q  <= ST_ACK_SETUP;
        end
        // drive the ack bit once SCL has dropped after bit 8
        ST_ACK_SETUP: if (scl_fall) begin
          sda_pull_o <= ack_q;
          st_q       <= ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (scl_fall) begin
          sda_pull_o <= 1'b0;
          st_q       <= ack_q ? ST_DATA : ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  assert_pull_on_low_scl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_s);
  assert_release_after_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pull_o && scl_fall) |=> !sda_pull_o);
  assert_ignore_silent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IGNORE) |-> !sda_pull_o);
  assert_disabled_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!sda_pull_o && st_q == ST_IDLE));
endmodule

// File: tb/sim_i2c_slave_rx.sv
`timescale 1ns/1ps
module sim_i2c_slave_rx;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b1, scl = 1'b1, sda_m = 1'b1;
  logic rd = 1'b0, oclr = 1'b0, aclr = 1'b0, aie = 1'b0, rie = 1'b0;
  logic pull, rdy, ovr, am, mode, irq;
  logic [7:0] rdata;
  wire sda_bus = sda_m & ~pull;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  i2c_slave_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .own_addr_i(OWN),
    .scl_i(scl), .sda_i(sda_bus), .buf_rd_i(rd), .ovr_clr_i(oclr),
    .amatch_clr_i(aclr), .amatch_ie_i(aie), .rx_ie_i(rie),
    .sda_pull_o(pull), .rx_data_o(rdata), .rx_ready_o(rdy),
    .overrun_o(ovr), .amatch_o(am), .xfer_mode_o(mode), .irq_o(irq)
  );

  typedef struct packed {
    logic [6:0] addr; logic rw; logic [7:0] data; logic rd_after; logic clr_after;
    logic aack; logic dack; logic rdy; logic ovr; logic [7:0] bufv; logic am; logic mode;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{7'h5A, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA5, 1'b1, 1'b0},
    '{7'h5A, 1'b0, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0},
    '{7'h5A, 1'b0, 8'h77, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0},
    '{7'h5A, 1'b0, 8'h77, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h77, 1'b1, 1'b0},
    '{7'h33, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77, 1'b0, 1'b0},
    '{7'h5A, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77, 1'b1, 1'b1},
    '{7'h5A, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0}
  };

  task automatic wq(); repeat (Q) @(posedge clk); #1; endtask
  task automatic wc(int n); repeat (n) @(posedge clk); #1; endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s); s = 1'b1; wc(1); s = 1'b0; wc(1); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask
  task automatic bus_bit(logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask
  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    sda_m = 1'b1; wq(); scl = 1'b1; wq();
    ack = ~sda_bus;
    wq(); scl = 1'b0; wq();
    if (ack) chk("R11 release after ninth fall", pull, 1'b0);
  endtask

  initial begin : watchdog
    wc(150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic a;
    wc(5); rst_n = 1'b1; wc(5);
    chk("R1 reset flags", {rdy, ovr, am, mode, irq, pull}, 6'b0);

    for (int v = 0; v < 7; v++) begin
      pulse(aclr);
      bus_start();
      send_byte({VECS[v].addr, VECS[v].rw}, a);
      chk("R2/R3/R10 address ack", a, VECS[v].aack);
      send_byte(VECS[v].data, a);
      chk("R4/R6/R7 data ack", a, VECS[v].dack);
      bus_stop();
      chk("R4/R5 rx_ready", rdy, VECS[v].rdy);
      chk("R6/R7 overrun", ovr, VECS[v].ovr);
      chk("R4/R6 buffer", rdata, VECS[v].bufv);
      chk("R2/R3 amatch", am, VECS[v].am);
      chk("R10 xfer_mode", mode, VECS[v].mode);
      if (VECS[v].rd_after) begin pulse(rd); chk("R5 read clears ready", rdy, 1'b0); end
      if (VECS[v].clr_after) begin pulse(oclr); chk("R7 overrun cleared", ovr, 1'b0); end
    end

    // R8 interrupt combining
    rie = 1'b1; aie = 1'b0; pulse(aclr);
    bus_start(); send_byte({OWN, 1'b0}, a); send_byte(8'h11, a); bus_stop();
    chk("R8 irq from ready", irq, 1'b1);
    pulse(rd);
    chk("R8 irq drops on read", irq, 1'b0);
    aie = 1'b1; wc(1);
    chk("R8 irq from amatch", irq, 1'b1);
    pulse(aclr);
    chk("R8 irq after amatch clear", irq, 1'b0);
    aie = 1'b0; rie = 1'b0;

    // R9 STOP then clocking without START
    bus_start(); send_byte({OWN, 1'b0}, a); bus_stop();
    sda_m = 1'b1; scl = 1'b0; wq();
    send_byte(8'hE1, a);
    chk("R9 no ack after stop", a, 1'b0);
    scl = 1'b1; wq();
    chk("R9 nothing stored after stop", rdy, 1'b0);
    scl = 1'b0; wq();

    // R9 repeated START mid-byte
    bus_start(); send_byte({OWN, 1'b0}, a);
    for (int i = 0; i < 4; i++) bus_bit(1'b0);
    bus_start(); send_byte({OWN, 1'b0}, a);
    chk("R9 address after repeated start", a, 1'b1);
    send_byte(8'h9C, a); bus_stop();
    chk("R9 byte after repeated start", rdata, 8'h9C);
    chk("R9 ready after repeated start", rdy, 1'b1);
    pulse(rd);

    // R12 disabled
    en = 1'b0; pulse(aclr);
    bus_start(); send_byte({OWN, 1'b0}, a);
    chk("R12 no ack when disabled", a, 1'b0);
    send_byte(8'h5E, a); bus_stop();
    chk("R12 no flags when disabled", {rdy, am, ovr}, 3'b0);
    en = 1'b1; wc(4);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule